// File: doc/BRIEF.md
# Three-Port Parallel I/O Register Block

This block gives a processor three 8-bit parallel ports on a small synchronous bus. Ports A and B are whole bytes. Port C is handled as two independent 4-bit halves. Each of the four groups is made an input or an output by one configuration word.

A single control address accepts two kinds of word, and the top bit tells them apart. One kind is a full setup word that sets the directions and the reported mode fields. The other kind sets or clears one chosen bit of port C. Output data is held in per-port latches. An input is read live from its pins. Only the basic mode is implemented. The strobed and bidirectional mode numbers in a setup word are decoded and reported on pins, but they change nothing else.

Top module: `pio_regblk`

## Requirements
- R1: The address selects the target: 0 is port A, 1 is port B, 2 is port C, and 3 is the control register. A write to addresses 0 to 2 loads that port's output latch, and each latch always drives its `_o` pins.
- R2: When `cs_ni` is high, a write strobe has no effect and `rdata_o` is 0.
- R3: After reset, every output latch is 0, every direction enable is 0 (all inputs), and both reported modes are 0.
- R4: A setup word has bit 7 = 1. A 1 in bit 4 makes A an input, a 1 in bit 3 makes C[7:4] an input, a 1 in bit 1 makes B an input, and a 1 in bit 0 makes C[3:0] an input. An output enable is all ones for an output group and all zeros for an input group. The word 0x98 gives A input, C-upper input, B output and C-lower output.
- R5: A setup word clears all three output latches to 0.
- R6: A bit word has bit 7 = 0. Bits 3:1 pick the port C bit and bit 0 is the new value. Only that latch bit changes, and bits 6:4 are ignored.
- R7: Reading a port returns the live pins for an input group and the latch for an output group. Port C chooses this per half.
- R8: A read of address 3 returns 0xFF. `rdata_o` is 0 unless both `cs_ni` and `rd_ni` are low.
- R9: `mode_a_o` reports setup bits 6:5, with 00 giving 0, 01 giving 1 and 1x giving 2. `mode_b_o` reports setup bit 2.
- R10: A write takes effect on the rising clock edge at which `cs_ni` and `wr_ni` are both low. Read data is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe_o | output | 8 | Port C output enables, one nibble per half |
| mode_a_o | output | 2 | Reported port A mode |
| mode_b_o | output | 1 | Reported port B mode |

## Verification
The setup words used include 0x98 (mixed directions, so one port C read merges pin and latch nibbles), 0xC5, 0xA0 and 0x9B. Together they separate the four direction bits and the 1x mode encoding. Port A is read twice with different pin values, which tells a live input from a latched one. Port A is also written while it is an input, to show that the pins still win on a read. Bit words are sent with bits 6:4 set and cleared, which shows that only the chosen bit moves and the ignored field cannot select a different bit. Strobes with chip select high show that a blocked write leaves the latch unchanged.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } pio_sel_e;

  typedef struct packed {
    logic [1:0] mode_a;
    logic       mode_b;
    logic       a_in;
    logic       cu_in;
    logic       b_in;
    logic       cl_in;
  } pio_cfg_t;

  localparam pio_cfg_t CFG_RESET = '{mode_a: 2'd0, mode_b: 1'b0,
                                     a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [DW-1:0] wdata_i,
  output pio_cfg_t      cfg_o,
  output logic          cfg_load_o,
  output logic          bit_we_o,
  output logic [IW-1:0] bit_idx_o,
  output logic          bit_val_o
);
  pio_cfg_t cfg_q;
  logic     is_setup;

  assign is_setup   = wdata_i[DW-1];
  assign cfg_load_o = ctl_we_i & is_setup;
  assign bit_we_o   = ctl_we_i & ~is_setup;
  assign bit_idx_o  = wdata_i[IW:1];
  assign bit_val_o  = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_load_o) begin
      cfg_q.mode_a <= wdata_i[6] ? 2'd2 : {1'b0, wdata_i[5]};
      cfg_q.a_in   <= wdata_i[4];
      cfg_q.cu_in  <= wdata_i[3];
      cfg_q.mode_b <= wdata_i[2];
      cfg_q.b_in   <= wdata_i[1];
      cfg_q.cl_in  <= wdata_i[0];
    end
  end

  assign cfg_o = cfg_q;

  // R9: mode 2 encoding for any word with bit 6 set
  assert_mode_two_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_load_o && wdata_i[6]) |=> (cfg_o.mode_a == 2'd2));

  // R6: a bit word leaves the configuration alone
  assert_bit_word_keeps_cfg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_we_o |=> $stable(cfg_o));

  // R2: without a control write nothing moves
  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(cfg_o));
endmodule

// File: rtl/pio_latch.sv
module pio_latch #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [DW-1:0] d_i,
  input  logic          bit_we_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic          bit_val_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (clr_i)    q <= '0;
    else if (we_i)     q <= d_i;
    else if (bit_we_i) q[bit_idx_i] <= bit_val_i;
  end

  assign q_o = q;

  assert_clear_on_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0));

  assert_single_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_we_i && !we_i && !clr_i) |=> ($countones(q_o ^ $past(q_o)) <= 1));

  assert_latch_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !we_i && !bit_we_i) |=> $stable(q_o));
endmodule

// File: rtl/pio_regblk.sv
module pio_regblk
  import pio_pkg::*;
#(
  parameter int DW = 8,
  localparam int HW = DW / 2,
  localparam int IW = $clog2(DW),
  localparam int NP = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o,
  output logic [1:0]    mode_a_o,
  output logic          mode_b_o
);
  pio_cfg_t      cfg;
  logic          wr_act, rd_act;
  logic          cfg_load, bit_we, bit_val;
  logic [IW-1:0] bit_idx;
  logic [DW-1:0] lat_q [NP];
  pio_sel_e      sel;

  assign sel    = pio_sel_e'(addr_i);
  assign wr_act = ~cs_ni & ~wr_ni;
  assign rd_act = ~cs_ni & ~rd_ni;

  pio_ctrl #(.DW(DW)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (wr_act && sel == SEL_CTRL),
    .wdata_i    (wdata_i),
    .cfg_o      (cfg),
    .cfg_load_o (cfg_load),
    .bit_we_o   (bit_we),
    .bit_idx_o  (bit_idx),
    .bit_val_o  (bit_val)
  );

  for (genvar g = 0; g < NP; g++) begin : g_port
    pio_latch #(.DW(DW)) i_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (cfg_load),
      .we_i      (wr_act && addr_i == 2'(g)),
      .d_i       (wdata_i),
      .bit_we_i  ((g == int'(SEL_C)) ? bit_we : 1'b0),
      .bit_idx_i (bit_idx),
      .bit_val_i (bit_val),
      .q_o       (lat_q[g])
    );
  end

  assign pa_o    = lat_q[0];
  assign pb_o    = lat_q[1];
  assign pc_o    = lat_q[2];
  assign pa_oe_o = {DW{~cfg.a_in}};
  assign pb_oe_o = {DW{~cfg.b_in}};
  assign pc_oe_o = {{HW{~cfg.cu_in}}, {HW{~cfg.cl_in}}};
  assign mode_a_o = cfg.mode_a;
  assign mode_b_o = cfg.mode_b;

  always_comb begin
    rdata_o = '0;
    if (rd_act) begin
      unique case (sel)
        SEL_A:    rdata_o = cfg.a_in ? pa_i : lat_q[0];
        SEL_B:    rdata_o = cfg.b_in ? pb_i : lat_q[1];
        SEL_C:    rdata_o = {cfg.cu_in ? pc_i[DW-1:HW] : lat_q[2][DW-1:HW],
                             cfg.cl_in ? pc_i[HW-1:0]  : lat_q[2][HW-1:0]};
        SEL_CTRL: rdata_o = '1;
      endcase
    end
  end

  assert_ctrl_reads_ones_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && addr_i == 2'd3) |-> (rdata_o == '1));

  assert_idle_bus_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_act |-> (rdata_o == '0));

  assert_deselected_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pc_oe_o)));

  assert_setup_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act && addr_i == 2'd3 && wdata_i[DW-1]) |=> (pa_o == '0 && pb_o == '0 && pc_o == '0));
endmodule

// File: tb/test_pio_regblk.sv
module test_pio_regblk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;
  logic [1:0] mode_a;
  logic       mode_b;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  pio_regblk i_pio_regblk (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe),
    .mode_a_o(mode_a), .mode_b_o(mode_b)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: compares read data with queued expectations
  always @(negedge clk) begin
    if (!cs_n && !rd_n && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata, e, t);
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
    @(posedge clk); #1;
    cs_n = sel_n; wr_n = 1'b0; addr = a; wdata = d;
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    chk(pa_oe, 8'h00, "R3 pa_oe reset");
    chk(pb_oe, 8'h00, "R3 pb_oe reset");
    chk(pc_oe, 8'h00, "R3 pc_oe reset");
    chk(pa_o | pb_o | pc_o, 8'h00, "R3 latches reset");
    chk({5'd0, mode_a, mode_b}, 8'h00, "R3 modes reset");
    chk(rdata, 8'h00, "R8 idle rdata");

    pa_i = 8'h5A;
    bus_rd(2'd0, 8'h5A, "R7 live pins A");
    pa_i = 8'hC3;
    bus_rd(2'd0, 8'hC3, "R7 unlatched A");

    bus_wr(2'd3, 8'h98, 1'b0);
    chk(pa_oe, 8'h00, "R4 98 A input");
    chk(pb_oe, 8'hFF, "R4 98 B output");
    chk(pc_oe, 8'h0F, "R4 98 C halves");
    chk({6'd0, mode_a}, 8'h00, "R9 98 mode A");

    bus_wr(2'd1, 8'h3C, 1'b0);
    chk(pb_o, 8'h3C, "R10 B latch pins");
    bus_rd(2'd1, 8'h3C, "R1 B readback");
    pc_i = 8'h70;
    bus_wr(2'd2, 8'hA5, 1'b0);
    chk(pc_o, 8'hA5, "R1 C latch pins");
    bus_rd(2'd2, 8'h75, "R7 C mixed halves");

    bus_wr(2'd1, 8'hFF, 1'b1);
    chk(pb_o, 8'h3C, "R2 deselected write");
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b0; addr = 2'd1;
    #2 chk(rdata, 8'h00, "R2 deselected read");
    rd_n = 1'b1;
    bus_rd(2'd3, 8'hFF, "R8 control read");

    bus_wr(2'd0, 8'h11, 1'b0);
    chk(pa_o, 8'h11, "R1 A latch");
    bus_rd(2'd0, 8'hC3, "R7 input wins over latch");

    bus_wr(2'd3, 8'h00, 1'b0);
    chk(pc_o, 8'hA4, "R6 clear bit0");
    bus_wr(2'd3, 8'h7D, 1'b0);
    chk(pc_o, 8'hE4, "R6 set bit6 ignore 6:4");
    bus_wr(2'd3, 8'h0E, 1'b0);
    chk(pc_o, 8'h64, "R6 clear bit7");
    chk(pc_oe, 8'h0F, "R6 dirs untouched");

    bus_wr(2'd3, 8'hC5, 1'b0);
    chk({6'd0, mode_a}, 8'h02, "R9 C5 mode A");
    chk({7'd0, mode_b}, 8'h01, "R9 C5 mode B");
    chk(pa_oe, 8'hFF, "R4 C5 A output");
    chk(pb_oe, 8'hFF, "R4 C5 B output");
    chk(pc_oe, 8'hF0, "R4 C5 C halves");
    chk(pa_o | pb_o | pc_o, 8'h00, "R5 latches cleared");

    bus_wr(2'd3, 8'hA0, 1'b0);
    chk({6'd0, mode_a}, 8'h01, "R9 A0 mode A");
    chk({7'd0, mode_b}, 8'h00, "R9 A0 mode B");

    bus_wr(2'd3, 8'h9B, 1'b0);
    chk(pa_oe | pb_oe | pc_oe, 8'h00, "R4 9B all inputs");
    pb_i = 8'h96;
    bus_rd(2'd1, 8'h96, "R7 B input live");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "R10 pending reads");
    finish_run();
  end
endmodule